// File: doc/BRIEF.md
# Two-Way Integer/FP Pairing Issue Stage

This block sits after decode in a two-wide in-order front end. Every cycle it may be offered one 64-bit fetch packet. The upper half holds the left-slot instruction, which is meant to be integer-class. The lower half holds the right-slot instruction, which is meant to be floating-point. Loads count as integer-class, including loads into FP registers. The decoder supplies a class bit, a load bit, a write enable and three register specifiers for each slot. Each specifier is 6 bits wide, so the integer and FP files share one 64-entry name space. The block then decides how many of the two instructions leave this cycle: zero, one or both.

The left instruction is always considered first. The right instruction can never leave ahead of the left one. If the left issues but the right cannot, the right instruction is moved into a single holding slot. From there it issues alone on a later cycle, and the next packet is not accepted until it has gone. The block records the destination of a load issued from the left slot for one cycle, which enforces the load delay on the following packet. A per-register pending mask from the memory side covers loads that stay outstanding for longer.

Top module: `pair_issue`

## Requirements
- R1: After reset, no instruction is held, no load is recorded, and with no packet offered both issue enables and `fetch_stall` are low.
- R2: If the left instruction issues but the pair is class-invalid (left is FP-class, or right is not FP-class), only the left instruction issues that cycle. The right instruction is held and then issues alone, with its word on `iss_r_word`.
- R3: A right-slot instruction from a packet never issues in a cycle in which that packet's left instruction does not issue.
- R4: If the left instruction writes a register (`l_wen`) that the right instruction reads, or also writes while `r_wen` is set, the right instruction does not issue with it. It is held instead.
- R5: If the right instruction reads the destination of a load in the left slot of the same packet, it issues no earlier than two cycles after the load.
- R6: An instruction that reads the destination of a load issued from the left slot in the previous cycle does not issue in this cycle.
- R7: An instruction whose source specifier s has bit s of `ld_pend` set does not issue. This applies to packet and held instructions alike.
- R8: While an instruction is held, `fetch_stall` is high and the left slot does not issue. Packet inputs have no effect on what issues in that time.
- R9: With no instruction held and a packet offered, `fetch_stall` is high exactly when the left instruction does not issue. The packet is consumed whenever the left instruction issues.
- R10: With no packet offered and nothing held, neither slot issues and `fetch_stall` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A fetch packet is offered |
| pkt | input | 2*IW | Packet; left instruction in upper half, right in lower half |
| l_fp | input | 1 | Left instruction is FP-class |
| l_load | input | 1 | Left instruction is a load |
| l_wen | input | 1 | Left instruction writes `l_dst` |
| l_dst | input | RW | Left destination specifier |
| l_s1 | input | RW | Left first source specifier |
| l_s2 | input | RW | Left second source specifier |
| r_fp | input | 1 | Right instruction is FP-class |
| r_wen | input | 1 | Right instruction writes `r_dst` |
| r_dst | input | RW | Right destination specifier |
| r_s1 | input | RW | Right first source specifier |
| r_s2 | input | RW | Right second source specifier |
| ld_pend | input | 2**RW | Per-register flag: a load to that register is still outstanding |
| iss_l | output | 1 | Left instruction issues this cycle |
| iss_r | output | 1 | Right (packet or held) instruction issues this cycle |
| iss_l_word | output | IW | Instruction word issued from the left slot |
| iss_r_word | output | IW | Instruction word issued from the right slot or holding slot |
| fetch_stall | output | 1 | The offered packet is not consumed this cycle |

## Verification
Several rules are checked by properties on every cycle. These are slot ordering, stall during a hold, the link between stall and packet consumption, idle behaviour, pending-mask blocking, and the one-cycle load shadow on the next packet. The bench sweeps every class combination and every kind of intra-packet dependence, with and without a left write. It also runs the load timelines cycle by cycle. These timelines show that a held instruction waits out the load, that it is released when the pending flag drops, and that a packet offered during a hold issues intact afterwards. Only scenarios can show these things, because they depend on which instruction word appears and in which cycle.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int IW = 32,
  parameter int RW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  input  logic [2*IW-1:0]       pkt,
  input  logic                  l_fp,
  input  logic                  l_load,
  input  logic                  l_wen,
  input  logic [RW-1:0]         l_dst,
  input  logic [RW-1:0]         l_s1,
  input  logic [RW-1:0]         l_s2,
  input  logic                  r_fp,
  input  logic                  r_wen,
  input  logic [RW-1:0]         r_dst,
  input  logic [RW-1:0]         r_s1,
  input  logic [RW-1:0]         r_s2,
  input  logic [(1<<RW)-1:0]    ld_pend,
  output logic                  iss_l,
  output logic                  iss_r,
  output logic [IW-1:0]         iss_l_word,
  output logic [IW-1:0]         iss_r_word,
  output logic                  fetch_stall
);
  localparam int NR = 1 << RW;

  logic          hold_v;
  logic [IW-1:0] h_word;
  logic [RW-1:0] h_s1, h_s2;
  logic          ld_v;
  logic [RW-1:0] ld_dst;

  function automatic logic busy(input logic [RW-1:0] s, input logic v,
                                input logic [RW-1:0] d, input logic [NR-1:0] p);
    return (v && s == d) || p[s];
  endfunction

  logic l_hz, r_hz, h_hz, pair_ok, r_dep, go_r_pkt;

  assign l_hz    = busy(l_s1, ld_v, ld_dst, ld_pend) | busy(l_s2, ld_v, ld_dst, ld_pend);
  assign r_hz    = busy(r_s1, ld_v, ld_dst, ld_pend) | busy(r_s2, ld_v, ld_dst, ld_pend);
  assign h_hz    = busy(h_s1, ld_v, ld_dst, ld_pend) | busy(h_s2, ld_v, ld_dst, ld_pend);
  assign pair_ok = !l_fp && r_fp;
  assign r_dep   = l_wen && (r_s1 == l_dst || r_s2 == l_dst || (r_wen && r_dst == l_dst));

  assign iss_l       = !hold_v && pkt_valid && !l_hz;
  assign go_r_pkt    = iss_l && pair_ok && !r_dep && !r_hz;
  assign iss_r       = hold_v ? !h_hz : go_r_pkt;
  assign fetch_stall = hold_v || (pkt_valid && !iss_l);
  assign iss_l_word  = pkt[2*IW-1:IW];
  assign iss_r_word  = hold_v ? h_word : pkt[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      h_word <= '0;
      h_s1   <= '0;
      h_s2   <= '0;
      ld_v   <= 1'b0;
      ld_dst <= '0;
    end else begin
      ld_v   <= iss_l && l_load && l_wen;
      ld_dst <= l_dst;
      if (hold_v) begin
        if (!h_hz) hold_v <= 1'b0;
      end else if (iss_l && !go_r_pkt) begin
        hold_v <= 1'b1;
        h_word <= pkt[IW-1:0];
        h_s1   <= r_s1;
        h_s2   <= r_s2;
      end
    end
  end
endmodule

module pair_issue_chk #(
  parameter int RW = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pkt_valid,
  input logic                  l_load,
  input logic                  l_wen,
  input logic [RW-1:0]         l_dst,
  input logic [RW-1:0]         l_s1,
  input logic [RW-1:0]         l_s2,
  input logic [RW-1:0]         r_s1,
  input logic [RW-1:0]         r_s2,
  input logic                  l_fp,
  input logic                  r_fp,
  input logic [(1<<RW)-1:0]    ld_pend,
  input logic                  hold_v,
  input logic                  iss_l,
  input logic                  iss_r,
  input logic                  fetch_stall
);
  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_r && !iss_l) |-> fetch_stall);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> (fetch_stall && !iss_l));

  assert_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !hold_v) |-> (fetch_stall != iss_l));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !hold_v) |-> (!iss_l && !iss_r && !fetch_stall));

  assert_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_l |-> (!ld_pend[l_s1] && !ld_pend[l_s2]));

  assert_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_l && (l_fp || !r_fp)) |=> hold_v);

  assert_load_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_l && l_load && l_wen) |=>
      !(iss_l && (l_s1 == $past(l_dst) || l_s2 == $past(l_dst))));

  assert_same_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_l && l_load && l_wen && (r_s1 == l_dst || r_s2 == l_dst)) |=> !iss_r);
endmodule

bind pair_issue pair_issue_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .l_load(l_load),
  .l_wen(l_wen), .l_dst(l_dst), .l_s1(l_s1), .l_s2(l_s2), .r_s1(r_s1),
  .r_s2(r_s2), .l_fp(l_fp), .r_fp(r_fp), .ld_pend(ld_pend),
  .hold_v(hold_v), .iss_l(iss_l), .iss_r(iss_r), .fetch_stall(fetch_stall)
);

// File: tb/sim_pair_issue.sv
module sim_pair_issue;
  localparam int IW = 32;
  localparam int RW = 6;

  logic clk = 0, rst_n = 0, pkt_valid = 0;
  logic [2*IW-1:0] pkt = '0;
  logic l_fp = 0, l_load = 0, l_wen = 0, r_fp = 0, r_wen = 0;
  logic [RW-1:0] l_dst = 0, l_s1 = 0, l_s2 = 0, r_dst = 0, r_s1 = 0, r_s2 = 0;
  logic [(1<<RW)-1:0] ld_pend = '0;
  logic iss_l, iss_r, fetch_stall;
  logic [IW-1:0] iss_l_word, iss_r_word;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pair_issue #(.IW(IW), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt(pkt),
    .l_fp(l_fp), .l_load(l_load), .l_wen(l_wen), .l_dst(l_dst),
    .l_s1(l_s1), .l_s2(l_s2), .r_fp(r_fp), .r_wen(r_wen), .r_dst(r_dst),
    .r_s1(r_s1), .r_s2(r_s2), .ld_pend(ld_pend), .iss_l(iss_l),
    .iss_r(iss_r), .iss_l_word(iss_l_word), .iss_r_word(iss_r_word),
    .fetch_stall(fetch_stall)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic expect3(input string tag, input logic el, input logic er, input logic es);
    chk({tag, " iss_l"}, 32'(iss_l), 32'(el));
    chk({tag, " iss_r"}, 32'(iss_r), 32'(er));
    chk({tag, " stall"}, 32'(fetch_stall), 32'(es));
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // neutral packet: distinct registers, legal pair
  task automatic base_pkt(input logic [31:0] lw, input logic [31:0] rw);
    pkt_valid = 1; pkt = {lw, rw};
    l_fp = 0; l_load = 0; l_wen = 1; l_dst = 6'd1; l_s1 = 6'd2; l_s2 = 6'd3;
    r_fp = 1; r_wen = 1; r_dst = 6'd40; r_s1 = 6'd41; r_s2 = 6'd42;
  endtask

  task automatic idle();
    pkt_valid = 0; pkt = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    next(); next();
    rst_n = 1;
    next(); settle();
    expect3("R1 reset", 0, 0, 0);
    expect3("R10 idle", 0, 0, 0);

    // R2 class sweep
    for (int lf = 0; lf < 2; lf++) begin
      for (int rf = 0; rf < 2; rf++) begin
        logic pair;
        pair = (lf == 0) && (rf == 1);
        next();
        base_pkt(32'hA000_0000 + 32'(lf*2+rf), 32'hB000_0000 + 32'(lf*2+rf));
        l_fp = 1'(lf); r_fp = 1'(rf);
        settle();
        expect3("R2 class", 1, pair, 0);
        chk("R2 left word", iss_l_word, 32'hA000_0000 + 32'(lf*2+rf));
        next(); idle(); settle();
        if (!pair) begin
          expect3("R2 held", 0, 1, 1);
          chk("R2 held word", iss_r_word, 32'hB000_0000 + 32'(lf*2+rf));
          next(); settle();
        end
        expect3("R10 after", 0, 0, 0);
      end
    end

    // R4 dependence sweep
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 2; w++) begin
        logic pair;
        pair = !(w == 1 && k != 0);
        next();
        base_pkt(32'hC000_0000 + 32'(k*2+w), 32'hD000_0000 + 32'(k*2+w));
        l_wen = 1'(w);
        if (k == 1) r_s1 = l_dst;
        if (k == 2) r_s2 = l_dst;
        if (k == 3) r_dst = l_dst;
        settle();
        expect3("R4 dep", 1, pair, 0);
        next(); idle(); settle();
        if (!pair) begin
          expect3("R4 held", 0, 1, 1);
          chk("R4 held word", iss_r_word, 32'hD000_0000 + 32'(k*2+w));
          next(); settle();
        end
        expect3("R10 after dep", 0, 0, 0);
      end
    end

    // R5 same-packet load use
    next();
    base_pkt(32'h1111_0001, 32'h2222_0001);
    l_load = 1; l_dst = 6'd5; r_s1 = 6'd5;
    settle();
    expect3("R5 load cycle", 1, 0, 0);
    next();
    base_pkt(32'h3333_0001, 32'h4444_0001);
    l_s1 = 6'd5;
    settle();
    expect3("R5 shadow", 0, 0, 1);
    expect3("R8 hold ignores pkt", 0, 0, 1);
    next(); settle();
    expect3("R5 held issues", 0, 1, 1);
    chk("R5 held word", iss_r_word, 32'h2222_0001);
    next(); settle();
    expect3("R8 pkt after hold", 1, 1, 0);
    chk("R8 left word", iss_l_word, 32'h3333_0001);
    chk("R8 right word", iss_r_word, 32'h4444_0001);

    // R6 next packet left consumer
    next();
    base_pkt(32'h5555_0001, 32'h6666_0001);
    l_load = 1; l_dst = 6'd7;
    settle();
    expect3("R6 load pair", 1, 1, 0);
    next();
    base_pkt(32'h5555_0002, 32'h6666_0002);
    l_s2 = 6'd7;
    settle();
    expect3("R6 left blocked", 0, 0, 1);
    expect3("R3 right waits", 0, 0, 1);
    next(); settle();
    expect3("R6 left released", 1, 1, 0);

    // R6 next packet right consumer
    next();
    base_pkt(32'h5555_0003, 32'h6666_0003);
    l_load = 1; l_dst = 6'd8;
    settle();
    expect3("R6 load pair b", 1, 1, 0);
    next();
    base_pkt(32'h5555_0004, 32'h6666_0004);
    r_s1 = 6'd8;
    settle();
    expect3("R6 right split", 1, 0, 0);
    next(); idle(); settle();
    expect3("R6 held go", 0, 1, 1);
    chk("R6 held word", iss_r_word, 32'h6666_0004);

    // R7 pending mask
    next();
    base_pkt(32'h7777_0001, 32'h8888_0001);
    ld_pend[9] = 1; l_s1 = 6'd9;
    settle();
    expect3("R7 left pend", 0, 0, 1);
    next();
    l_s1 = 6'd2; r_s2 = 6'd9;
    settle();
    expect3("R7 right pend", 1, 0, 0);
    next(); idle(); settle();
    expect3("R7 held pend", 0, 0, 1);
    next(); settle();
    expect3("R7 held still", 0, 0, 1);
    next(); ld_pend[9] = 0; settle();
    expect3("R7 held free", 0, 1, 1);
    chk("R7 held word", iss_r_word, 32'h8888_0001);
    next(); settle();
    expect3("R10 end", 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule